// File: doc/BRIEF.md
# Program Flow Sequencer

This block owns the program counter of a DSP core that addresses memory in 16-bit words. Each cycle it may take one already-decoded flow operation, together with the following inputs:

- the result of the condition test, which is evaluated elsewhere;
- a target address;
- the length of the current instruction in words;
- a count operand.

From these it produces the next program counter. It also produces single-cycle pulses for an error interrupt and a trap interrupt, and a load strobe with a value for the repeat counter of the execution unit.

Three small stacks sit inside the block. One holds return addresses. One holds loop iteration counts. One holds loop end addresses.

- Subroutine calls and returns use the return stack only.
- A block loop pushes onto all three stacks.
- When a plain sequential step lands on the end address at the top of the end-address stack, the block closes the loop. It either branches back to the body start or unwinds.

Every push onto a full stack and every pop from an empty stack is refused. The error interrupt is raised instead, and the program counter is left where it was.

Top module: `flowseq_top`

## Requirements
- R1: After a synchronous active-high reset, `pcOut` equals `RESET_PC`, all pulse outputs are 0 and all three stacks are empty.
- R2: A jump (opCode 1) with `condTrue` high loads `target` into the PC. With `condTrue` low it adds `instrLen` to the PC.
- R3: A call (opCode 2) with `condTrue` high pushes PC+`instrLen` onto the return stack and loads `target`. If the return stack is full, `errIrq` pulses for one cycle and the PC holds. With `condTrue` low the PC advances by `instrLen` and nothing is pushed.
- R4: A return (opCode 3) with `condTrue` high pops the return stack into the PC. If that stack is empty, `errIrq` pulses and the PC holds. With `condTrue` low the PC advances by 1.
- R5: A conditional execute (opCode 4) advances the PC by 1 when `condTrue` is high and by 2 when it is low.
- R6: A loop setup (opCode 5) with a nonzero `countIn` pushes PC+2 onto the return stack, `countIn` onto the count stack and `target` (the end address) onto the end-address stack. It then sets the PC to PC+2.
- R7: A loop setup with `countIn` equal to 0 pushes nothing and sets the PC to `target`+1.
- R8: The loop pushes are attempted in a fixed order: return stack, then count stack, then end-address stack. The first one that finds its stack full raises `errIrq` and holds the PC. Pushes before it in the order still take place.
- R9: A sequential step (opCode 0) taken while a loop is open and the PC equals the top end address closes the loop. If the top count is above 1, the count is decremented and the PC is reloaded from the top of the return stack. If the count is 1, all three stacks are popped and the PC advances by `instrLen`.
- R10: A repeat (opCode 6) with a nonzero `countIn` pulses `repLoad` with `repCount` = `countIn` and advances the PC by 1. A zero count advances the PC by 2 and gives no `repLoad`.
- R11: A trap (opCode 7) pulses `trapIrq` for one cycle regardless of `condTrue`, and the PC holds.
- R12: A sequential step outside a loop end advances the PC by `instrLen`. While `opValid` is low the PC holds and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | 0 step, 1 jump, 2 call, 3 return, 4 execute, 5 loop, 6 repeat, 7 trap |
| condTrue | input | 1 | Result of the condition test |
| target | input | AW (16) | Branch target or loop end address |
| instrLen | input | LW (2) | Length of the current instruction in words |
| countIn | input | CW (16) | Loop or repeat count |
| pcOut | output | AW (16) | Program counter |
| errIrq | output | 1 | Error interrupt pulse (stack overflow or underflow) |
| trapIrq | output | 1 | Trap interrupt pulse |
| repLoad | output | 1 | Repeat counter load strobe |
| repCount | output | CW (16) | Value for the repeat counter |

## Verification
The bench builds the block with its defaults: 16-bit addresses and counts, 2-bit lengths, and stacks 4 entries deep. That depth lets four nested calls or loops fill a stack, so overflow on both call and loop setup, and underflow on return, can be reached in a handful of operations. Draining the return stack while the count and end-address stacks stay full produces the case where the second loop push fails after the first has taken place. A three-pass loop covers both the count-decrement branch-back and the final unwind.

// File: rtl/flowseq_pkg.sv
package flowseq_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_EXEC = 3'd4,
    OP_LOOP = 3'd5,
    OP_REP  = 3'd6,
    OP_TRAP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_LEN,
    PC_ONE,
    PC_TWO,
    PC_TARGET,
    PC_RETTOP,
    PC_ENDNEXT
  } pcsel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   retPush;
    logic   retPop;
    logic   retLink;   // 1: push PC+len, 0: push PC+2
    logic   cntPush;
    logic   cntPop;
    logic   cntDec;
    logic   eaPush;
    logic   eaPop;
    logic   errSet;
    logic   trapSet;
    logic   repSet;
    pcsel_e pcSel;
  } strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic retFull;
    logic retEmpty;
    logic cntFull;
    logic eaFull;
    logic loopOpen;
    logic atEnd;
    logic cntMore;
  } status_t;

endpackage

// File: rtl/flowseq_stack.sv
module flowseq_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         decTop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] fill;
  logic [PW-1:0] topIdx;

  assign topIdx = fill - PW'(1);
  assign full   = (fill == PW'(DEPTH));
  assign empty  = (fill == '0);
  assign top    = mem[topIdx[IW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (push) fill <= fill + PW'(1);
    else if (pop) fill <= fill - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (push) mem[fill[IW-1:0]] <= din;
    else if (decTop) mem[topIdx[IW-1:0]] <= mem[topIdx[IW-1:0]] - W'(1);
  end

  // R8 / R3: control never pushes onto a full stack
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R4: control never pops an empty stack
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);

endmodule

// File: rtl/flowseq_ctrl.sv
module flowseq_ctrl
  import flowseq_pkg::*;
(
  input  logic         opValid,
  input  logic [2:0]   opCode,
  input  logic         condTrue,
  input  logic         countZero,
  input  status_t      stat,
  output strobe_t      stb
);
  op_e op;
  assign op = op_e'(opCode);

  always_comb begin
    stb = '0;
    stb.pcSel = PC_HOLD;
    if (opValid) begin
      unique case (op)
        OP_STEP: begin
          if (stat.loopOpen && stat.atEnd) begin
            if (stat.cntMore) begin
              stb.cntDec = 1'b1;
              stb.pcSel  = PC_RETTOP;
            end else begin
              stb.retPop = 1'b1;
              stb.cntPop = 1'b1;
              stb.eaPop  = 1'b1;
              stb.pcSel  = PC_LEN;
            end
          end else begin
            stb.pcSel = PC_LEN;
          end
        end
        OP_JMP: stb.pcSel = condTrue ? PC_TARGET : PC_LEN;
        OP_CALL: begin
          if (!condTrue) stb.pcSel = PC_LEN;
          else if (stat.retFull) stb.errSet = 1'b1;
          else begin
            stb.retPush = 1'b1;
            stb.retLink = 1'b1;
            stb.pcSel   = PC_TARGET;
          end
        end
        OP_RET: begin
          if (!condTrue) stb.pcSel = PC_ONE;
          else if (stat.retEmpty) stb.errSet = 1'b1;
          else begin
            stb.retPop = 1'b1;
            stb.pcSel  = PC_RETTOP;
          end
        end
        OP_EXEC: stb.pcSel = condTrue ? PC_ONE : PC_TWO;
        OP_LOOP: begin
          if (countZero) stb.pcSel = PC_ENDNEXT;
          else if (stat.retFull) stb.errSet = 1'b1;
          else if (stat.cntFull) begin
            stb.retPush = 1'b1;
            stb.errSet  = 1'b1;
          end else if (stat.eaFull) begin
            stb.retPush = 1'b1;
            stb.cntPush = 1'b1;
            stb.errSet  = 1'b1;
          end else begin
            stb.retPush = 1'b1;
            stb.cntPush = 1'b1;
            stb.eaPush  = 1'b1;
            stb.pcSel   = PC_TWO;
          end
        end
        OP_REP: begin
          if (countZero) stb.pcSel = PC_TWO;
          else begin
            stb.repSet = 1'b1;
            stb.pcSel  = PC_ONE;
          end
        end
        OP_TRAP: stb.trapSet = 1'b1;
        default: stb.pcSel = PC_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/flowseq_path.sv
module flowseq_path
  import flowseq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          CW       = 16,
  parameter int          LW       = 2,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       stb,
  input  logic [AW-1:0] target,
  input  logic [LW-1:0] instrLen,
  input  logic [CW-1:0] countIn,
  output status_t       stat,
  output logic [AW-1:0] pcOut,
  output logic          errIrq,
  output logic          trapIrq,
  output logic          repLoad,
  output logic [CW-1:0] repCount
);
  logic [AW-1:0] pcQ, pcNext, pcPlusLen, pcPlusTwo, retDin;
  logic [AW-1:0] retTop, eaTop;
  logic [CW-1:0] cntTop;
  logic          cntEmpty, eaEmpty;

  assign pcPlusLen = pcQ + AW'(instrLen);
  assign pcPlusTwo = pcQ + AW'(2);
  assign retDin    = stb.retLink ? pcPlusLen : pcPlusTwo;

  flowseq_stack #(.W(AW), .DEPTH(DEPTH)) u_retStack (
    .clk(clk), .rst(rst), .push(stb.retPush), .pop(stb.retPop), .decTop(1'b0),
    .din(retDin), .top(retTop), .full(stat.retFull), .empty(stat.retEmpty)
  );

  flowseq_stack #(.W(CW), .DEPTH(DEPTH)) u_cntStack (
    .clk(clk), .rst(rst), .push(stb.cntPush), .pop(stb.cntPop), .decTop(stb.cntDec),
    .din(countIn), .top(cntTop), .full(stat.cntFull), .empty(cntEmpty)
  );

  flowseq_stack #(.W(AW), .DEPTH(DEPTH)) u_eaStack (
    .clk(clk), .rst(rst), .push(stb.eaPush), .pop(stb.eaPop), .decTop(1'b0),
    .din(target), .top(eaTop), .full(stat.eaFull), .empty(eaEmpty)
  );

  assign stat.loopOpen = !eaEmpty && !cntEmpty;
  assign stat.atEnd    = (pcQ == eaTop);
  assign stat.cntMore  = (cntTop > CW'(1));

  always_comb begin
    unique case (stb.pcSel)
      PC_LEN:     pcNext = pcPlusLen;
      PC_ONE:     pcNext = pcQ + AW'(1);
      PC_TWO:     pcNext = pcPlusTwo;
      PC_TARGET:  pcNext = target;
      PC_RETTOP:  pcNext = retTop;
      PC_ENDNEXT: pcNext = target + AW'(1);
      default:    pcNext = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ      <= AW'(RESET_PC);
      errIrq   <= 1'b0;
      trapIrq  <= 1'b0;
      repLoad  <= 1'b0;
      repCount <= '0;
    end else begin
      pcQ     <= pcNext;
      errIrq  <= stb.errSet;
      trapIrq <= stb.trapSet;
      repLoad <= stb.repSet;
      if (stb.repSet) repCount <= countIn;
    end
  end

  assign pcOut = pcQ;

  // R1: reset puts the PC at its reset value
  a_r1_reset_pc: assert property (@(posedge clk) $past(rst) |-> (pcOut == AW'(RESET_PC)));
  // R9: a loop back-edge always targets a non-empty return stack
  a_r9_backedge_has_link: assert property (@(posedge clk) disable iff (rst)
    stb.cntDec |-> !stat.retEmpty);

endmodule

// File: rtl/flowseq_top.sv
module flowseq_top
  import flowseq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          CW       = 16,
  parameter int          LW       = 2,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opValid,
  input  logic [2:0]    opCode,
  input  logic          condTrue,
  input  logic [AW-1:0] target,
  input  logic [LW-1:0] instrLen,
  input  logic [CW-1:0] countIn,
  output logic [AW-1:0] pcOut,
  output logic          errIrq,
  output logic          trapIrq,
  output logic          repLoad,
  output logic [CW-1:0] repCount
);
  strobe_t stb;
  status_t stat;

  flowseq_ctrl u_ctrl (
    .opValid(opValid), .opCode(opCode), .condTrue(condTrue),
    .countZero(countIn == '0), .stat(stat), .stb(stb)
  );

  flowseq_path #(.AW(AW), .CW(CW), .LW(LW), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_path (
    .clk(clk), .rst(rst), .stb(stb), .target(target), .instrLen(instrLen),
    .countIn(countIn), .stat(stat), .pcOut(pcOut), .errIrq(errIrq),
    .trapIrq(trapIrq), .repLoad(repLoad), .repCount(repCount)
  );

  // R2: taken jump lands on the target
  a_r2_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd1 && condTrue) |=> (pcOut == $past(target)));
  // R5: conditional execute moves the PC by one or two
  a_r5_exec_step: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd4) |=>
      (pcOut == $past(pcOut) + ($past(condTrue) ? AW'(1) : AW'(2))));
  // R11: trap always pulses the trap interrupt
  a_r11_trap_pulse: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd7) |=> trapIrq);
  // R12: idle cycles hold the PC and raise nothing
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> ($stable(pcOut) && !errIrq && !trapIrq && !repLoad));

endmodule

// File: tb/flowseq_top_test.sv
module flowseq_top_test;
  localparam logic [2:0] STEP = 3'd0, JMP = 3'd1, CALL = 3'd2, RET = 3'd3,
                         EXEC = 3'd4, LOOP = 3'd5, REP = 3'd6, TRAP = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        condTrue = 1'b0;
  logic [15:0] target = '0;
  logic [1:0]  instrLen = 2'd1;
  logic [15:0] countIn = '0;
  logic [15:0] pcOut;
  logic        errIrq, trapIrq, repLoad;
  logic [15:0] repCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flowseq_top uut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode), .condTrue(condTrue),
    .target(target), .instrLen(instrLen), .countIn(countIn), .pcOut(pcOut),
    .errIrq(errIrq), .trapIrq(trapIrq), .repLoad(repLoad), .repCount(repCount)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, return at the next falling edge
  task automatic doOp(input logic [2:0] op, input logic c, input logic [15:0] tgt,
                      input logic [1:0] len, input logic [15:0] cnt);
    opValid = 1'b1; opCode = op; condTrue = c; target = tgt; instrLen = len; countIn = cnt;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    check("R1 pc", pcOut, 16'h0);
    check("R1 pulses", {errIrq, trapIrq, repLoad}, 0);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R1 return stack empty err", errIrq, 1);
    check("R4 underflow pc holds", pcOut, 16'h0);
    doOp(RET, 1'b0, 0, 1, 0);
    check("R4 false ret pc+1", pcOut, 16'h1);
    check("R4 err one cycle", errIrq, 0);
  endtask

  task automatic t_step_jump_exec();
    doReset();
    doOp(STEP, 1'b0, 0, 1, 0);
    check("R12 step len1", pcOut, 16'h1);
    doOp(STEP, 1'b0, 0, 2, 0);
    check("R12 step len2", pcOut, 16'h3);
    idle();
    check("R12 idle holds", pcOut, 16'h3);
    doOp(JMP, 1'b0, 16'h100, 2, 0);
    check("R2 jump not taken", pcOut, 16'h5);
    doOp(JMP, 1'b1, 16'h100, 2, 0);
    check("R2 jump taken", pcOut, 16'h100);
    doOp(EXEC, 1'b1, 0, 1, 0);
    check("R5 exec true", pcOut, 16'h101);
    doOp(EXEC, 1'b0, 0, 1, 0);
    check("R5 exec false", pcOut, 16'h103);
  endtask

  task automatic t_call();
    doReset();
    doOp(JMP, 1'b1, 16'h40, 1, 0);
    doOp(CALL, 1'b0, 16'h200, 2, 0);
    check("R3 call not taken", pcOut, 16'h42);
    doOp(CALL, 1'b1, 16'h200, 2, 0);
    check("R3 call taken", pcOut, 16'h200);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R4 return to link", pcOut, 16'h44);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R3 false call pushed nothing", errIrq, 1);
  endtask

  task automatic t_call_overflow();
    doReset();
    for (int i = 1; i <= 4; i++) doOp(CALL, 1'b1, 16'(i * 16), 1, 0);
    check("R3 nested calls", pcOut, 16'h40);
    doOp(CALL, 1'b1, 16'h50, 1, 0);
    check("R3 overflow err", errIrq, 1);
    check("R3 overflow pc holds", pcOut, 16'h40);
    idle();
    check("R3 err pulse ends", errIrq, 0);
    for (int i = 3; i >= 0; i--) begin
      doOp(RET, 1'b1, 0, 1, 0);
      check("R4 unwind", pcOut, 16'(i * 16 + 1));
    end
    doOp(RET, 1'b1, 0, 1, 0);
    check("R4 underflow err", errIrq, 1);
    check("R4 underflow pc", pcOut, 16'h1);
  endtask

  task automatic t_loop();
    doReset();
    doOp(JMP, 1'b1, 16'h20, 1, 0);
    doOp(LOOP, 1'b1, 16'h24, 2, 3);
    check("R6 loop enter", pcOut, 16'h22);
    for (int it = 0; it < 3; it++) begin
      doOp(STEP, 1'b0, 0, 1, 0);
      check("R9 body", pcOut, 16'h23);
      doOp(STEP, 1'b0, 0, 1, 0);
      check("R9 body end", pcOut, 16'h24);
      doOp(STEP, 1'b0, 0, 1, 0);
      check("R9 loop close", pcOut, (it < 2) ? 16'h22 : 16'h25);
    end
    doOp(STEP, 1'b0, 0, 1, 0);
    check("R9 after loop", pcOut, 16'h26);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R9 stacks popped", errIrq, 1);
    doOp(LOOP, 1'b1, 16'h40, 2, 0);
    check("R7 zero loop skip", pcOut, 16'h41);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R7 nothing pushed", errIrq, 1);
  endtask

  task automatic t_loop_overflow();
    doReset();
    for (int i = 0; i < 4; i++) doOp(LOOP, 1'b1, 16'h30, 2, 1);
    check("R6 four loops", pcOut, 16'h8);
    doOp(LOOP, 1'b1, 16'h30, 2, 1);
    check("R8 ret full err", errIrq, 1);
    check("R8 ret full pc holds", pcOut, 16'h8);
    for (int i = 3; i >= 0; i--) begin
      doOp(RET, 1'b1, 0, 1, 0);
      check("R6 loop links", pcOut, 16'(i * 2 + 2));
    end
    doOp(LOOP, 1'b1, 16'h30, 2, 1);
    check("R8 count full err", errIrq, 1);
    check("R8 count full pc holds", pcOut, 16'h2);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R8 earlier push kept", pcOut, 16'h4);
    doOp(RET, 1'b1, 0, 1, 0);
    check("R8 single push only", errIrq, 1);
  endtask

  task automatic t_rep_trap();
    doReset();
    doOp(REP, 1'b0, 0, 1, 16'd5);
    check("R10 rep load", repLoad, 1);
    check("R10 rep count", repCount, 16'd5);
    check("R10 rep pc+1", pcOut, 16'h1);
    doOp(REP, 1'b0, 0, 1, 16'd0);
    check("R10 zero rep no load", repLoad, 0);
    check("R10 zero rep pc+2", pcOut, 16'h3);
    doOp(TRAP, 1'b0, 0, 1, 0);
    check("R11 trap pulse", trapIrq, 1);
    check("R11 trap pc holds", pcOut, 16'h3);
    idle();
    check("R11 trap pulse ends", trapIrq, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_step_jump_exec();
    t_call();
    t_call_overflow();
    t_loop();
    t_loop_overflow();
    t_rep_trap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule